// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Engine with Per-Word Handshake

This block is a single-channel DMA engine that moves words from one peripheral into memory without the processor. Software first writes three setup values through a small write-only register port: a source identifier for the peripheral, the first memory address to fill, and the length of the transfer in bytes. It then writes a start command. From then on the engine waits for the peripheral. Each time the peripheral has a word ready, the engine asks the processor for the memory bus. Once it holds the bus, it drives the target address and acknowledges the peripheral, which puts its word on the bus. The engine then gives the bus back until the next word is ready.

The state machine has four states. `ST_IDLE` is not busy and waits for a start. On a valid start it moves to `ST_WAIT`, which is busy and waits for `dreq`. `ST_WAIT` moves to `ST_BREQ` when `dreq` is high. In `ST_BREQ` the engine asks for the bus and waits for `bus_gnt`. `ST_BREQ` moves to `ST_ACK` when `bus_gnt` is high. `ST_ACK` owns the bus, acknowledges the peripheral and waits for `dreq` to fall. When `dreq` falls, `ST_ACK` steps the address and the remaining count. It then goes back to `ST_WAIT`, or to `ST_IDLE` with the done flag set if that was the last word. A start whose length is zero, or is not a whole number of words, stays in `ST_IDLE` and sets the error flag.

Top module: `dma_req_ack`

## Requirements
- R1: Register writes use `cfg_addr`: 0 is the source identifier, 1 is the first destination address, 2 is the byte count, and 3 is the command register, where `cfg_wdata` bit 0 = 1 means start. Any register write or start made while `busy` is 1 is ignored.
- R2: A start issued while idle with a valid count makes `busy` 1 from the next cycle and clears `done` and `err`.
- R3: While busy and waiting, a high `dreq` raises `bus_req` one cycle later. Until `bus_gnt` is seen, `dack` stays 0 and `mem_addr` stays 0.
- R4: One cycle after `bus_gnt` is sampled in the bus-request state, `dack` is 1, `mem_addr` shows the current destination and `src_id` shows the source identifier. These hold for as long as `dreq` stays high. `dack` falls one cycle after `dreq` is sampled low.
- R5: After each word, the destination advances by `WORD_BYTES` and the remaining count drops by `WORD_BYTES`. `bus_req` is 0 between words.
- R6: When the last word completes, `done` becomes 1 and `busy` becomes 0 in the same cycle. `done` stays 1 until the next start. Later `dreq` pulses raise neither `bus_req` nor `dack`.
- R7: A start with a count of zero, or a count that is not a multiple of `WORD_BYTES`, sets `err`. It starts no transfer: `busy` and `bus_req` stay 0.
- R8: After reset, `busy`, `done`, `err`, `bus_req` and `dack` are 0, and `mem_addr` and `src_id` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| dreq | input | 1 | Peripheral word-ready request |
| dack | output | 1 | Acknowledge to the peripheral |
| bus_req | output | 1 | Memory bus request to the processor |
| bus_gnt | input | 1 | Memory bus grant from the processor |
| mem_addr | output | AW | Memory target address; 0 unless acknowledging |
| src_id | output | AW | Source identifier; 0 unless acknowledging |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky transfer-complete flag |
| err | output | 1 | Rejected start |

## Verification
Every result comes out of a register one clock edge after the input that causes it. A start is sampled at edge k and shows as `busy` after edge k. `dreq` sampled at an edge raises `bus_req` after that edge, and the grant sampled at an edge raises `dack` after that edge. A low `dreq` sampled at an edge drops `dack` and updates `done` and `busy` after that edge. The bench drives its inputs just after the falling edge. It updates a behavioural model at each rising edge from the same sampled inputs, and it compares every output with the model at the next falling edge. Scenario checks follow the same one-edge timing.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BREQ = 2'd2,
        ST_ACK  = 2'd3
    } dma_state_t;

    localparam logic [1:0] REG_SRC = 2'd0;
    localparam logic [1:0] REG_DST = 2'd1;
    localparam logic [1:0] REG_CNT = 2'd2;
    localparam logic [1:0] REG_CMD = 2'd3;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [AW-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == REG_SRC) src_q <= wr_data;
            if (wr_sel == REG_DST) dst_q <= wr_data;
            if (wr_sel == REG_CNT) cnt_q <= wr_data;
        end
    end
endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] byte_cnt,
    output logic [AW-1:0] cur_addr,
    output logic          last_word
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= base_addr;
            remain   <= byte_cnt;
        end else if (step) begin
            cur_addr <= cur_addr + STEP;
            remain   <= remain - STEP;
        end
    end

    assign last_word = (remain == STEP);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic cnt_ok,
    input  logic dreq,
    input  logic bus_gnt,
    input  logic last_word,
    output logic load,
    output logic step,
    output logic busy,
    output logic bus_req,
    output logic dack,
    output logic done,
    output logic err
);
    dma_state_t state, state_nx;
    logic       start_ok;

    assign start_ok = start_cmd && (state == ST_IDLE);
    assign load     = start_ok && cnt_ok;
    assign step     = (state == ST_ACK) && !dreq;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (load)    state_nx = ST_WAIT;
            ST_WAIT: if (dreq)    state_nx = ST_BREQ;
            ST_BREQ: if (bus_gnt) state_nx = ST_ACK;
            ST_ACK:  if (!dreq)   state_nx = last_word ? ST_IDLE : ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_ok) begin
                done <= 1'b0;
                err  <= !cnt_ok;
            end else if (step && last_word) begin
                done <= 1'b1;
            end
        end
    end

    always_comb begin
        busy    = 1'b1;
        bus_req = 1'b0;
        dack    = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_WAIT: ;
            ST_BREQ: bus_req = 1'b1;
            ST_ACK: begin
                bus_req = 1'b1;
                dack    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dma_req_ack.sv
module dma_req_ack
    import dma_pkg::*;
#(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dreq,
    output logic          dack,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] src_id,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam logic [AW-1:0] WB = AW'(WORD_BYTES);

    logic [AW-1:0] src_q, dst_q, cnt_q, cur_addr;
    logic          load, step, last_word, start_cmd, cnt_ok;

    assign start_cmd = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[0] && !busy;
    assign cnt_ok    = (cnt_q != '0) && ((cnt_q % WB) == '0);

    dma_cfg_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && !busy), .wr_sel(cfg_addr), .wr_data(cfg_wdata),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q)
    );

    dma_ptr #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .base_addr(dst_q), .byte_cnt(cnt_q),
        .cur_addr(cur_addr), .last_word(last_word)
    );

    dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .cnt_ok(cnt_ok),
        .dreq(dreq), .bus_gnt(bus_gnt), .last_word(last_word),
        .load(load), .step(step), .busy(busy), .bus_req(bus_req),
        .dack(dack), .done(done), .err(err)
    );

    assign mem_addr = dack ? cur_addr : '0;
    assign src_id   = dack ? src_q : '0;
endmodule

// File: rtl/dma_req_ack_chk.sv
module dma_req_ack_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dreq,
    input logic          dack,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          done,
    input logic          err
);
    assert_grant_before_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack) |-> $past(bus_gnt));

    assert_ack_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && dreq) |=> dack);

    assert_no_addr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dack |-> (mem_addr == '0));

    assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> bus_req);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !dack));

    assert_err_no_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);
endmodule

bind dma_req_ack dma_req_ack_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .dack(dack), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_addr(mem_addr), .busy(busy), .done(done), .err(err)
);

// File: tb/sim_dma_req_ack.sv
`timescale 1ns/1ps
module sim_dma_req_ack;
    localparam int AW = 16;
    localparam int WB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dreq = 1'b0;
    logic          bus_gnt = 1'b0;
    logic          gnt_en = 1'b1;
    logic          dack, bus_req, busy, done, err;
    logic [AW-1:0] mem_addr, src_id;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_req_ack #(.AW(AW), .WORD_BYTES(WB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .src_id(src_id),
        .busy(busy), .done(done), .err(err)
    );

    // processor side: grant follows the request
    always @(negedge clk) begin
        #1 bus_gnt = gnt_en && bus_req;
    end

    // behavioural reference model
    int m_phase, m_src, m_dst, m_cnt, m_addr, m_rem;
    bit m_done, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_src = 0; m_dst = 0; m_cnt = 0;
            m_addr = 0; m_rem = 0; m_done = 0; m_err = 0;
        end else begin
            bit was_idle;
            was_idle = (m_phase == 0);
            case (m_phase)
                0: if (cfg_we && cfg_addr == 3 && cfg_wdata[0]) begin
                        m_done = 0;
                        if (m_cnt != 0 && m_cnt % WB == 0) begin
                            m_err = 0; m_addr = m_dst; m_rem = m_cnt; m_phase = 1;
                        end else m_err = 1;
                    end
                1: if (dreq) m_phase = 2;
                2: if (bus_gnt) m_phase = 3;
                default: if (!dreq) begin
                        m_addr = (m_addr + WB) % (1 << AW);
                        m_rem  = m_rem - WB;
                        if (m_rem == 0) begin m_phase = 0; m_done = 1; end
                        else m_phase = 1;
                    end
            endcase
            if (cfg_we && was_idle) begin
                if (cfg_addr == 0) m_src = int'(cfg_wdata);
                if (cfg_addr == 1) m_dst = int'(cfg_wdata);
                if (cfg_addr == 2) m_cnt = int'(cfg_wdata);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_phase != 0), "R2 busy", busy, m_phase != 0);
            chk(bus_req == (m_phase >= 2), "R3 bus_req", bus_req, m_phase >= 2);
            chk(dack == (m_phase == 3), "R4 dack", dack, m_phase == 3);
            chk(int'(mem_addr) == (m_phase == 3 ? m_addr : 0), "R5 mem_addr",
                mem_addr, m_phase == 3 ? m_addr : 0);
            chk(int'(src_id) == (m_phase == 3 ? m_src : 0), "R4 src_id",
                src_id, m_phase == 3 ? m_src : 0);
            chk(done == m_done, "R6 done", done, m_done);
            chk(err == m_err, "R7 err", err, m_err);
        end
    end

    task automatic step_cyc();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        step_cyc();
        cfg_we = 1; cfg_addr = a; cfg_wdata = AW'(d);
        step_cyc();
        cfg_we = 0;
    endtask

    int got_addr[$];

    // one four-phase word from the peripheral; holds dreq for extra cycles
    task automatic one_word(input int hold);
        int guard = 0;
        dreq = 1;
        while (!dack && guard < 50) begin step_cyc(); guard++; end
        got_addr.push_back(int'(mem_addr));
        for (int i = 0; i < hold; i++) begin
            step_cyc();
            chk(dack == 1'b1, "R4 ack held", dack, 1);
        end
        dreq = 0;
        step_cyc();
        chk(dack == 1'b0, "R4 ack falls", dack, 0);
        chk(bus_req == 1'b0, "R5 bus released", bus_req, 0);
    endtask

    initial begin
        #160000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step_cyc();
        chk(!busy && !done && !err && !bus_req && !dack, "R8 reset flags", 0, 0);
        chk(mem_addr == 0 && src_id == 0, "R8 reset buses", mem_addr, 0);
        rst_n = 1;

        // normal three-word transfer
        wr(0, 'h00A0); wr(1, 'h1000); wr(2, 12); wr(3, 1);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        got_addr.delete();
        one_word(2); one_word(0); one_word(1);
        chk(got_addr.size() == 3, "R5 word count", got_addr.size(), 3);
        for (int i = 0; i < 3; i++)
            chk(got_addr[i] == 'h1000 + 4*i, "R5 addr step", got_addr[i], 'h1000 + 4*i);
        chk(done && !busy, "R6 done set", {done, busy}, 2);

        // requests after completion are ignored
        dreq = 1;
        for (int i = 0; i < 5; i++) begin
            step_cyc();
            chk(!bus_req && !dack, "R6 dreq ignored", bus_req, 0);
        end
        dreq = 0;

        // invalid counts
        wr(2, 0); wr(3, 1);
        chk(err && !busy && !done, "R7 zero count", {err, busy, done}, 4);
        wr(2, 6); wr(3, 1);
        chk(err && !busy, "R7 partial word", {err, busy}, 2);
        step_cyc();
        chk(!bus_req, "R7 no bus", bus_req, 0);

        // writes during a transfer are ignored
        wr(1, 'h2000); wr(2, 8); wr(3, 1);
        chk(!err && busy, "R2 err cleared", {err, busy}, 1);
        wr(1, 'h3000); wr(2, 4); wr(3, 1);
        got_addr.delete();
        // delayed grant
        gnt_en = 0; dreq = 1;
        repeat (4) begin
            step_cyc();
            chk(!dack && mem_addr == 0, "R3 wait grant", mem_addr, 0);
        end
        chk(bus_req == 1'b1, "R3 request up", bus_req, 1);
        gnt_en = 1;
        one_word(0); one_word(0);
        chk(got_addr.size() == 2, "R1 length kept", got_addr.size(), 2);
        if (got_addr.size() == 2) begin
            chk(got_addr[0] == 'h2000, "R1 dst kept", got_addr[0], 'h2000);
            chk(got_addr[1] == 'h2004, "R5 second addr", got_addr[1], 'h2004);
        end
        chk(done && !busy, "R6 done again", {done, busy}, 2);

        repeat (2) step_cyc();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule